// File: doc/BRIEF.md
# Reset and Option-Load Sequencer

This block steers a small controller core from reset into normal execution. It watches an active-low reset pin and filters it so that only a low level lasting several oscillator clocks is taken as a reset. Once the pin is released, it waits a programmable number of oscillator clocks. It also waits for an external "oscillator stable" indication. Only then does it open a fixed option-loading window.

Inside that window the sequencer reads a small set of configuration words from a nonvolatile option store. The store is modelled as a synchronous read port that returns data one clock after the strobe. The sequencer copies those words into option registers. The reads come first in the window and the rest of the window is idle padding, so the window length is the same whatever the number of words.

On the last clock of the window the sequencer pulses a program-counter clear. On the next clock it raises the run enable for the core, together with a one-clock "options valid" pulse. A separate power-on clear from the supply monitor places the block in the reset-held condition.

Top module: `boot_sequencer`

## Requirements
- R1: A low level on `rst_pin_n` takes effect only after it has been sampled low on `RST_MIN` (default 4) consecutive rising clock edges. A shorter low pulse leaves `cpu_run` and `opt_words` unchanged.
- R2: After the reset is released, the first option read comes no earlier than `STAB_CYCLES + 2` clocks after the first high sample of the pin.
- R3: Inside the window, `opt_rd` is high on exactly `OPT_WORDS` consecutive clocks, starting on the first window clock, with `opt_addr` going 0, 1, … `OPT_WORDS-1`. No read strobe occurs outside the window.
- R4: The word returned on `opt_data` one clock after a strobe is stored in option register `addr`. Register `i` appears on `opt_words[i*OPT_W +: OPT_W]`.
- R5: The window lasts `LOAD_CYCLES` (default 512) clocks. `pc_clear` is a single-clock pulse on the last of them.
- R6: `cpu_run` rises on the clock after `pc_clear`. `opt_valid` is high only on that first run clock.
- R7: A reset that is accepted during the wait, the window or the run phase drops `cpu_run` and `opt_valid` and stops any further strobes in the same clock in which it is accepted. The option registers read zero from the next clock on. The next release restarts the sequence from address 0.
- R8: While `osc_stable` is low, the sequencer stays in the wait phase after the counter has expired. The window opens on the clock after `osc_stable` is first seen high.
- R9: A low `por_n` clears the outputs at once and holds the block as if a reset were accepted. A release with the pin high then boots exactly like a pin release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin_n | input | 1 | External reset pin, active low, filtered |
| osc_stable | input | 1 | Oscillator has settled |
| opt_rd | output | 1 | Read strobe to the option store |
| opt_addr | output | ADDR_W | Option word address |
| opt_data | input | OPT_W | Option store read data, one clock after the strobe |
| opt_words | output | OPT_WORDS*OPT_W | Option registers, word i at bits i*OPT_W |
| pc_clear | output | 1 | Program-counter clear pulse on the last window clock |
| cpu_run | output | 1 | Core run enable |
| opt_valid | output | 1 | One-clock pulse on the first run clock |

## Verification
A miscounted filter would show at once. It would either drop `cpu_run` on a three-clock glitch, or leave it high on the fourth low sample. A miscounted wait or window counter would shift the first `opt_rd` or the `pc_clear` pulse by whole clocks. The scoreboard, which knows the exact clock of every strobe, pulse and run edge, catches this at the first event. A wrong address register or a skipped capture shows in `opt_words`, which is compared at the run edge. A sequencer that does not go back to idle shows as a strobe or run edge that no item in the queue explains.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_WAIT = 2'd1,
    BS_LOAD = 2'd2,
    BS_RUN  = 2'd3
  } boot_state_e;

  // True while the window slot is one of the read slots.
  function automatic logic in_read_slot(input int unsigned slot, input int unsigned words);
    return slot < words;
  endfunction

  // True on the final slot of a span of the given length.
  function automatic logic span_last(input int unsigned slot, input int unsigned len);
    return slot == len - 1;
  endfunction

endpackage

// File: rtl/rst_filter.sv
module rst_filter #(
  parameter int RST_MIN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic rst_active
);
  localparam int FW = $clog2(RST_MIN + 1);
  localparam logic [FW-1:0] FULL = FW'(RST_MIN);

  logic [FW-1:0] low_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              low_cnt <= FULL;
    else if (pin_n)          low_cnt <= '0;
    else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
  end

  assign rst_active = (low_cnt == FULL);
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import boot_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 40,
  parameter int LOAD_CYCLES = 512,
  parameter int OPT_WORDS   = 4,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_active,
  input  logic              osc_stable,
  output logic              in_load,
  output logic              opt_rd,
  output logic [ADDR_W-1:0] opt_addr,
  output logic              pc_clear,
  output logic              cpu_run,
  output logic              opt_valid
);
  localparam int CNT_MAX = (STAB_CYCLES > LOAD_CYCLES) ? STAB_CYCLES : LOAD_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);

  boot_state_e   state;
  logic [CW-1:0] cnt;
  logic          fresh;
  logic          stab_end;
  logic          load_end;

  assign stab_end = span_last(32'(cnt), STAB_CYCLES);
  assign load_end = span_last(32'(cnt), LOAD_CYCLES);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= BS_IDLE;
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (rst_active) begin
      state <= BS_IDLE;
      cnt   <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= 1'b0;
      case (state)
        BS_IDLE: begin
          state <= BS_WAIT;
          cnt   <= '0;
        end
        BS_WAIT: begin
          if (stab_end) begin
            if (osc_stable) begin
              state <= BS_LOAD;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BS_LOAD: begin
          if (load_end) begin
            state <= BS_RUN;
            cnt   <= '0;
            fresh <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= BS_RUN;
      endcase
    end
  end

  assign in_load   = (state == BS_LOAD);
  assign opt_rd    = in_load && !rst_active && in_read_slot(32'(cnt), OPT_WORDS);
  assign opt_addr  = cnt[ADDR_W-1:0];
  assign pc_clear  = in_load && !rst_active && load_end;
  assign cpu_run   = (state == BS_RUN) && !rst_active;
  assign opt_valid = fresh && !rst_active;
endmodule

// File: rtl/opt_capture.sv
module opt_capture #(
  parameter int OPT_WORDS = 4,
  parameter int OPT_W     = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       rst_active,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [OPT_W-1:0]           data,
  output logic [OPT_WORDS*OPT_W-1:0] words
);
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= rd;
      addr_q <= addr;
    end
  end

  for (genvar g = 0; g < OPT_WORDS; g++) begin : g_word
    logic [OPT_W-1:0] word_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                word_q <= '0;
      else if (rst_active)                       word_q <= '0;
      else if (rd_q && addr_q == ADDR_W'(g))     word_q <= data;
    end
    assign words[g*OPT_W +: OPT_W] = word_q;
  end
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer #(
  parameter int STAB_CYCLES = 40,
  parameter int LOAD_CYCLES = 512,
  parameter int OPT_WORDS   = 4,
  parameter int OPT_W       = 8,
  parameter int RST_MIN     = 4,
  localparam int ADDR_W     = (OPT_WORDS > 1) ? $clog2(OPT_WORDS) : 1
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       rst_pin_n,
  input  logic                       osc_stable,
  output logic                       opt_rd,
  output logic [ADDR_W-1:0]          opt_addr,
  input  logic [OPT_W-1:0]           opt_data,
  output logic [OPT_WORDS*OPT_W-1:0] opt_words,
  output logic                       pc_clear,
  output logic                       cpu_run,
  output logic                       opt_valid
);
  logic rst_active;
  logic in_load;

  rst_filter #(.RST_MIN(RST_MIN)) u_filt (
    .clk        (clk),
    .por_n      (por_n),
    .pin_n      (rst_pin_n),
    .rst_active (rst_active)
  );

  boot_fsm #(
    .STAB_CYCLES (STAB_CYCLES),
    .LOAD_CYCLES (LOAD_CYCLES),
    .OPT_WORDS   (OPT_WORDS),
    .ADDR_W      (ADDR_W)
  ) u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .rst_active (rst_active),
    .osc_stable (osc_stable),
    .in_load    (in_load),
    .opt_rd     (opt_rd),
    .opt_addr   (opt_addr),
    .pc_clear   (pc_clear),
    .cpu_run    (cpu_run),
    .opt_valid  (opt_valid)
  );

  opt_capture #(
    .OPT_WORDS (OPT_WORDS),
    .OPT_W     (OPT_W),
    .ADDR_W    (ADDR_W)
  ) u_cap (
    .clk        (clk),
    .por_n      (por_n),
    .rst_active (rst_active),
    .rd         (opt_rd),
    .addr       (opt_addr),
    .data       (opt_data),
    .words      (opt_words)
  );
endmodule

// File: rtl/boot_sequencer_chk.sv
module boot_sequencer_chk #(
  parameter int OPT_WORDS = 4,
  parameter int OPT_W     = 8,
  parameter int ADDR_W    = 2
) (
  input logic                       clk,
  input logic                       por_n,
  input logic                       rst_active,
  input logic                       in_load,
  input logic                       osc_stable,
  input logic                       opt_rd,
  input logic [ADDR_W-1:0]          opt_addr,
  input logic [OPT_WORDS*OPT_W-1:0] opt_words,
  input logic                       pc_clear,
  input logic                       cpu_run,
  input logic                       opt_valid
);
  AST_RUN_DROPS_ON_RESET: assert property (@(posedge clk) disable iff (!por_n)
    rst_active |-> (!cpu_run && !opt_valid && !opt_rd)); // R7

  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!por_n)
    opt_rd |-> in_load); // R3

  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!por_n)
    (opt_rd && $past(opt_rd)) |-> (opt_addr == $past(opt_addr) + 1'b1)); // R3

  AST_VALID_FIRST_RUN: assert property (@(posedge clk) disable iff (!por_n)
    opt_valid |-> (cpu_run && !$past(cpu_run))); // R6

  AST_RUN_AFTER_PC: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_run) |-> $past(pc_clear)); // R5

  AST_WORDS_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
    $past(rst_active) |-> (opt_words == '0)); // R7

  AST_LOAD_NEEDS_OSC: assert property (@(posedge clk) disable iff (!por_n)
    $rose(in_load) |-> $past(osc_stable)); // R8
endmodule

bind boot_sequencer boot_sequencer_chk #(
  .OPT_WORDS (OPT_WORDS),
  .OPT_W     (OPT_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_active (rst_active),
  .in_load    (in_load),
  .osc_stable (osc_stable),
  .opt_rd     (opt_rd),
  .opt_addr   (opt_addr),
  .opt_words  (opt_words),
  .pc_clear   (pc_clear),
  .cpu_run    (cpu_run),
  .opt_valid  (opt_valid)
);

// File: tb/sim_boot_sequencer.sv
module sim_boot_sequencer;
  localparam int STAB = 40;
  localparam int LOADN = 512;
  localparam int NW = 4;
  localparam int W = 8;
  localparam int EV_RD = 1, EV_PC = 2, EV_RUN = 3;

  typedef struct {
    int    kind;
    int    cyc;
    int    val;
    string req;
  } ev_t;

  logic            clk = 1'b0;
  logic            por_n, rst_pin_n, osc_stable;
  logic            opt_rd, pc_clear, cpu_run, opt_valid;
  logic [1:0]      opt_addr;
  logic [W-1:0]    opt_data = '0;
  logic [NW*W-1:0] opt_words;
  logic [W-1:0]    mem [NW];
  logic [NW*W-1:0] exp_words;

  int  cyc = 0;
  int  nchk = 0;
  int  nerr = 0;
  bit  done = 0;
  bit  run_prev = 0;
  ev_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (opt_rd) opt_data <= mem[opt_addr];

  boot_sequencer u0 (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .osc_stable(osc_stable),
    .opt_rd(opt_rd), .opt_addr(opt_addr), .opt_data(opt_data),
    .opt_words(opt_words), .pc_clear(pc_clear), .cpu_run(cpu_run),
    .opt_valid(opt_valid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int at, input int val, input string req);
    ev_t e;
    e.kind = kind; e.cyc = at; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic take(input int kind, input int val);
    ev_t e;
    if (q.size() == 0) begin
      nchk++; nerr++;
      $display("FAIL R3: unexpected event kind %0d value %0d at cycle %0d (got event expected none)",
               kind, val, cyc);
    end else begin
      e = q.pop_front();
      chk(e.req, 64'(kind), 64'(e.kind));
      chk(e.req, 64'(cyc), 64'(e.cyc));
      chk(e.req, 64'(val), 64'(e.val));
    end
  endtask

  // Monitor: every strobe, pc clear and run edge must match the queue head.
  always @(negedge clk) begin
    if (opt_rd)               take(EV_RD, int'(opt_addr));
    if (pc_clear)             take(EV_PC, 0);
    if (cpu_run && !run_prev) take(EV_RUN, int'(opt_valid));
    run_prev = cpu_run;
  end

  task automatic fill_mem(input logic [W-1:0] seed);
    for (int i = 0; i < NW; i++) begin
      mem[i] = seed + W'(i * 37);
      exp_words[i*W +: W] = mem[i];
    end
  endtask

  // Release the pin (or power-on clear) and queue the expected boot events.
  task automatic boot(input bit via_por, input int osc_at);
    int c0, first;
    @(negedge clk);
    c0 = cyc;
    if (via_por) por_n = 1'b1; else rst_pin_n = 1'b1;
    first = c0 + 2 + STAB;                                  // R2
    if (osc_at >= 0 && c0 + osc_at + 1 > first) first = c0 + osc_at + 1; // R8
    for (int i = 0; i < NW; i++) push(EV_RD, first + i, i, "R3");
    push(EV_PC, first + LOADN - 1, 0, "R5");
    push(EV_RUN, first + LOADN, 1, "R6");
    if (osc_at >= 0) begin
      repeat (osc_at) @(negedge clk);
      osc_stable = 1'b1;
    end
  endtask

  task automatic wait_queue();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic check_boot();
    wait_queue();
    chk("R4", opt_words, exp_words);
    chk("R6", cpu_run, 1);
    @(negedge clk);
    chk("R6", opt_valid, 0);
    chk("R6", cpu_run, 1);
  endtask

  task automatic long_reset();
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", cpu_run, 1);        // three low samples: not yet accepted
    @(negedge clk);
    chk("R7", cpu_run, 0);        // fourth low sample accepted
    chk("R7", opt_valid, 0);
    repeat (2) @(negedge clk);
    chk("R7", opt_words, 0);
  endtask

  initial begin
    por_n = 1'b0; rst_pin_n = 1'b0; osc_stable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", cpu_run, 0);
    chk("R9", opt_words, 0);
    chk("R9", opt_rd, 0);
    por_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1", cpu_run, 0);
    chk("R1", opt_rd, 0);

    // Boot with the oscillator already stable.
    fill_mem(8'h11);
    osc_stable = 1'b1;
    boot(1'b0, -1);
    check_boot();

    // Three-clock glitch while running: no effect (R1).
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1", cpu_run, 1);
    end
    chk("R1", opt_words, exp_words);

    // Accepted reset during run, then a boot with a late oscillator.
    long_reset();
    osc_stable = 1'b0;
    fill_mem(8'hA0);
    boot(1'b0, 80);
    check_boot();

    // Reset accepted just after the window opens: one strobe only (R7).
    long_reset();
    begin
      int c0, first;
      fill_mem(8'h3C);
      @(negedge clk);
      c0 = cyc;
      rst_pin_n = 1'b1;
      first = c0 + 2 + STAB;
      push(EV_RD, first, 0, "R7");
      while (cyc < first - 3) @(negedge clk);
      rst_pin_n = 1'b0;
      repeat (600) @(negedge clk);
      chk("R7", 64'(q.size()), 0);
      chk("R7", opt_words, 0);
      chk("R7", cpu_run, 0);
    end

    // Full restart from address 0 after the aborted window.
    fill_mem(8'h5C);
    boot(1'b0, -1);
    check_boot();

    // Power-on clear while running, then boot from its release (R9).
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R9", cpu_run, 0);
    chk("R9", opt_words, 0);
    chk("R9", opt_valid, 0);
    fill_mem(8'hC3);
    boot(1'b1, -1);
    check_boot();

    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion (cycle %0d)", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule